// File: doc/BRIEF.md
# SDRAM Activation Timing Guard

This block watches the command stream going to a four-bank SDRAM and decides, cycle by cycle, whether each command respects the row-activation rules. Every cycle it takes a decoded command (no-op, activate, read, write, precharge) with a bank number and a row number. It keeps, for each bank, whether a row is open and which row that is. It also keeps three kinds of spacing windows: activate-to-column, activate-to-activate within one bank, and activate-to-activate across banks.

The three spacing limits are given as parameters in picoseconds, together with the clock period. At elaboration time each limit is turned into a whole number of cycles by dividing it by the period and rounding up. With the defaults, 18 ns at an 8 ns clock gives 3 cycles, 60 ns gives 8 and 12 ns gives 2.

A command that breaks a rule is reported by a one-cycle pulse that says which rule was broken and which bank was addressed. The same rule also sets a sticky flag. A rejected command leaves all bank state untouched, so the block can sit inside a controller as a guard as well as beside a bus as a monitor.

Top module: `sdram_act_guard`

## Requirements
- R1: Each limit in cycles is the ceiling of its picosecond value divided by the clock period, with a minimum of 1. With the defaults, a column command may come 3 cycles after an activate, a same-bank activate 8 cycles after the previous one, and an activate to another bank 2 cycles after the previous accepted activate.
- R2: A read (cmd 2) or write (cmd 3) to a bank with no open row raises violation bit 0.
- R3: A read or write to an open bank fewer than the column-delay cycles after that bank's accepted activate raises violation bit 1. At exactly that many cycles it is legal.
- R4: An activate (cmd 1) to a bank whose row is still open raises violation bit 2.
- R5: An activate to a closed bank fewer than the same-bank cycles after that bank's last accepted activate raises violation bit 3. At exactly that many cycles it is legal.
- R6: An activate to a bank other than the one in the last accepted activate, fewer than the cross-bank cycles after it, raises violation bit 4. An activate to the same bank is not subject to this rule.
- R7: An accepted activate opens its bank and stores the row. A precharge (cmd 4) closes its bank. A precharge to a closed bank, a no-op (cmd 0) and the codes 5 to 7 change nothing. Bank b is bit b of the open vector and bits b*ROW_W upward of the row vector.
- R8: A command that raises any violation changes no bank state and starts no spacing window.
- R9: Violation bits from one command appear on the pulse output in the cycle after it, each bit set for every rule broken, with the addressed bank on the bank output. Otherwise the pulse output is zero and the bank output is 0.
- R10: Each sticky bit sets together with its pulse bit and stays set until reset.
- R11: Reset (active low, asynchronous) closes every bank, clears all rows, pulses and sticky bits, and clears every spacing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge |
| bank_i | input | BANK_W | Bank addressed by the command |
| row_i | input | ROW_W | Row for an activate |
| bank_open_o | output | 2**BANK_W | Per-bank open flag |
| open_row_o | output | 2**BANK_W*ROW_W | Per-bank open row, bank b at bits b*ROW_W upward |
| viol_pulse_o | output | 5 | One-cycle violation bits: 0 closed, 1 column delay, 2 open, 3 same-bank spacing, 4 cross-bank spacing |
| viol_bank_o | output | BANK_W | Bank of the flagged command |
| viol_sticky_o | output | 5 | Sticky copy of the violation bits |

## Verification
The assertions assume that bank_i and row_i carry meaning only alongside a non-idle command, and that inputs are stable around the rising edge. The stimulus changes every input on the falling edge and uses only the five defined command codes. Reset is held across at least one rising edge before the first command. The spacing windows are then exercised at one cycle short of each limit and at the limit itself, so that each rounding result is checked at its edge.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } cmd_e;

   localparam int unsigned VIOL_N      = 5;
   localparam int unsigned V_CLOSED    = 0;
   localparam int unsigned V_RCD       = 1;
   localparam int unsigned V_OPEN      = 2;
   localparam int unsigned V_SAME_BANK = 3;
   localparam int unsigned V_CROSS     = 4;

   function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                input int unsigned tck_ps);
      int unsigned c;
      c = (t_ps + tck_ps - 1) / tck_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int unsigned CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);

   generate
      if (CYCLES > 1) begin : g_count
         localparam int unsigned CW   = $clog2(CYCLES);
         localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (start_i)       cnt_q <= LOAD;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end

         assign done_o = (cnt_q == '0);

         assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LOAD);
         assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=> (cnt_q == LOAD));
      end else begin : g_none
         assign done_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
   parameter int unsigned ROW_W   = 12,
   parameter int unsigned RCD_CYC = 3,
   parameter int unsigned RC_CYC  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_go_i,
   input  logic             pre_go_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             rcd_ok_o,
   output logic             rc_ok_o
);

   logic             open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (act_go_i) begin
         open_q <= 1'b1;
         row_q  <= row_i;
      end else if (pre_go_i) begin
         open_q <= 1'b0;
      end
   end

   sdram_gap_timer #(.CYCLES(RCD_CYC)) u_rcd (
      .clk(clk), .rst_n(rst_n), .start_i(act_go_i), .done_o(rcd_ok_o));

   sdram_gap_timer #(.CYCLES(RC_CYC)) u_rc (
      .clk(clk), .rst_n(rst_n), .start_i(act_go_i), .done_o(rc_ok_o));

   assign open_o = open_q;
   assign row_o  = row_q;

   assert_open_after_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(act_go_i));
   assert_close_after_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_q) |-> $past(pre_go_i));
   assert_row_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !act_go_i |=> $stable(row_q));

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
   import sdram_guard_pkg::*;
#(
   parameter int unsigned BANK_W  = 2,
   parameter int unsigned ROW_W   = 12,
   parameter int unsigned TCK_PS  = 8000,
   parameter int unsigned TRCD_PS = 18000,
   parameter int unsigned TRC_PS  = 60000,
   parameter int unsigned TRRD_PS = 12000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [2:0]                  cmd_i,
   input  logic [BANK_W-1:0]           bank_i,
   input  logic [ROW_W-1:0]            row_i,
   output logic [(1<<BANK_W)-1:0]      bank_open_o,
   output logic [(1<<BANK_W)*ROW_W-1:0] open_row_o,
   output logic [4:0]                  viol_pulse_o,
   output logic [BANK_W-1:0]           viol_bank_o,
   output logic [4:0]                  viol_sticky_o
);

   localparam int unsigned NBANK    = 1 << BANK_W;
   localparam int unsigned RCD_CYC  = ps_to_cycles(TRCD_PS, TCK_PS);
   localparam int unsigned RC_CYC   = ps_to_cycles(TRC_PS, TCK_PS);
   localparam int unsigned RRD_CYC  = ps_to_cycles(TRRD_PS, TCK_PS);

   generate
      if (TCK_PS == 0) begin : g_bad_tck
         $error("sdram_act_guard: TCK_PS must be non-zero");
      end
      if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
         $error("sdram_act_guard: BANK_W out of range");
      end
      if (ROW_W < 1) begin : g_bad_row
         $error("sdram_act_guard: ROW_W must be positive");
      end
   endgenerate

   // command decode
   logic is_act, is_rw, is_pre;
   always_comb begin
      is_act = (cmd_i == CMD_ACT);
      is_rw  = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
      is_pre = (cmd_i == CMD_PRE);
   end

   // per-bank state
   logic [NBANK-1:0] open_w, rcd_ok_w, rc_ok_w, act_go, pre_go;
   logic [ROW_W-1:0] row_w [NBANK];

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         sdram_bank_state #(
            .ROW_W(ROW_W), .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC)
         ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_go_i(act_go[b]), .pre_go_i(pre_go[b]), .row_i(row_i),
            .open_o(open_w[b]), .row_o(row_w[b]),
            .rcd_ok_o(rcd_ok_w[b]), .rc_ok_o(rc_ok_w[b]));
         assign open_row_o[b*ROW_W +: ROW_W] = row_w[b];
      end
   endgenerate

   assign bank_open_o = open_w;

   // cross-bank activate window
   logic              rrd_ok, act_ok, have_last_q;
   logic [BANK_W-1:0] last_bank_q;

   sdram_gap_timer #(.CYCLES(RRD_CYC)) u_rrd (
      .clk(clk), .rst_n(rst_n), .start_i(act_ok), .done_o(rrd_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_last_q <= 1'b0;
         last_bank_q <= '0;
      end else if (act_ok) begin
         have_last_q <= 1'b1;
         last_bank_q <= bank_i;
      end
   end

   // rule evaluation
   logic [4:0] viol;
   always_comb begin
      viol              = '0;
      viol[V_CLOSED]    = is_rw  && !open_w[bank_i];
      viol[V_RCD]       = is_rw  &&  open_w[bank_i] && !rcd_ok_w[bank_i];
      viol[V_OPEN]      = is_act &&  open_w[bank_i];
      viol[V_SAME_BANK] = is_act && !open_w[bank_i] && !rc_ok_w[bank_i];
      viol[V_CROSS]     = is_act &&  have_last_q && (bank_i != last_bank_q) && !rrd_ok;
      act_ok            = is_act && (viol == '0);
   end

   always_comb begin
      act_go = '0;
      pre_go = '0;
      act_go[bank_i] = act_ok;
      pre_go[bank_i] = is_pre;
   end

   // reporting
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_pulse_o  <= '0;
         viol_bank_o   <= '0;
         viol_sticky_o <= '0;
      end else begin
         viol_pulse_o  <= viol;
         viol_bank_o   <= (viol != '0) ? bank_i : '0;
         viol_sticky_o <= viol_sticky_o | viol;
      end
   end

   assert_rw_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && !bank_open_o[bank_i]) |=> viol_pulse_o[V_CLOSED]);
   assert_act_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && bank_open_o[bank_i]) |=> viol_pulse_o[V_OPEN]);
   assert_reject_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_act && !is_pre) |=> $stable(bank_open_o));
   assert_cross_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok && have_last_q && bank_i != last_bank_q) |-> rrd_ok);

   generate
      for (genvar v = 0; v < 5; v++) begin : g_sticky_chk
         assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            viol_sticky_o[v] |=> viol_sticky_o[v]);
         assert_pulse_sets_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            viol_pulse_o[v] |-> viol_sticky_o[v]);
      end
   endgenerate

endmodule

// File: tb/tb_sdram_act_guard.sv
module tb_sdram_act_guard;

   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd_i = 3'd0;
   logic [1:0]  bank_i = 2'd0;
   logic [11:0] row_i = '0;
   logic [3:0]  bank_open_o;
   logic [47:0] open_row_o;
   logic [4:0]  viol_pulse_o;
   logic [1:0]  viol_bank_o;
   logic [4:0]  viol_sticky_o;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_act_guard dut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .row_i(row_i),
      .bank_open_o(bank_open_o), .open_row_o(open_row_o),
      .viol_pulse_o(viol_pulse_o), .viol_bank_o(viol_bank_o),
      .viol_sticky_o(viol_sticky_o));

   typedef struct packed {
      logic [2:0]  cmd;
      logic [1:0]  bank;
      logic [11:0] row;
      logic [4:0]  viol;
      logic [3:0]  open;
   } vec_t;

   // cmd: 0 nop, 1 act, 2 rd, 3 wr, 4 pre; limits 3 / 8 / 2 cycles
   localparam vec_t TBL [18] = '{
      '{3'd1, 2'd0, 12'd5,    5'b00000, 4'b0001}, // R7 open b0
      '{3'd2, 2'd0, 12'd0,    5'b00010, 4'b0001}, // R3 one cycle after act
      '{3'd4, 2'd0, 12'd0,    5'b00000, 4'b0000}, // R7 close b0
      '{3'd1, 2'd0, 12'd6,    5'b01000, 4'b0000}, // R5, R6 not for same bank
      '{3'd1, 2'd1, 12'd7,    5'b00000, 4'b0010}, // R7 open b1
      '{3'd1, 2'd2, 12'd100,  5'b10000, 4'b0010}, // R6 cross-bank too soon
      '{3'd2, 2'd1, 12'd0,    5'b00010, 4'b0010}, // R3 two cycles
      '{3'd3, 2'd1, 12'd0,    5'b00000, 4'b0010}, // R3 exactly three cycles
      '{3'd2, 2'd2, 12'd0,    5'b00001, 4'b0010}, // R2 closed bank
      '{3'd1, 2'd2, 12'd9,    5'b00000, 4'b0110}, // R8 earlier reject left b2 closed
      '{3'd1, 2'd1, 12'd3,    5'b10100, 4'b0110}, // R4 plus R6 together
      '{3'd4, 2'd3, 12'd0,    5'b00000, 4'b0110}, // R7 precharge of closed bank
      '{3'd0, 2'd0, 12'd0,    5'b00000, 4'b0110}, // R7 no-op
      '{3'd1, 2'd0, 12'd2,    5'b00000, 4'b0111}, // R5 long after
      '{3'd2, 2'd0, 12'd0,    5'b00010, 4'b0111}, // R3
      '{3'd0, 2'd0, 12'd0,    5'b00000, 4'b0111}, // R9 pulse clears
      '{3'd3, 2'd0, 12'd0,    5'b00000, 4'b0111}, // R3 legal at limit
      '{3'd1, 2'd3, 12'd4095, 5'b00000, 4'b1111}  // R7 last bank, full row
   };

   function automatic string tag_of(input logic [4:0] v);
      if (v[0]) return "R2";
      if (v[2]) return "R4";
      if (v[3]) return "R5";
      if (v[4]) return "R6";
      if (v[1]) return "R3";
      return "R7";
   endfunction

   task automatic check(input string req, input string what,
                        input logic [47:0] act, input logic [47:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive at falling edge, results visible at next falling edge
   task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [11:0] r);
      cmd_i  = c;
      bank_i = b;
      row_i  = r;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R11 reset state
      check("R11", "open", 48'(bank_open_o), 48'h0);
      check("R11", "pulse", 48'(viol_pulse_o), 48'h0);
      check("R11", "sticky", 48'(viol_sticky_o), 48'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 18; i++) begin
         issue(TBL[i].cmd, TBL[i].bank, TBL[i].row);
         check(tag_of(TBL[i].viol), "pulse", 48'(viol_pulse_o), 48'(TBL[i].viol));
         check("R7", "open", 48'(bank_open_o), 48'(TBL[i].open));
         check("R9", "bank", 48'(viol_bank_o),
               (TBL[i].viol != 0) ? 48'(TBL[i].bank) : 48'h0);
      end

      // R10 all sticky bits collected, still set after a clean cycle
      issue(3'd0, 2'd0, 12'd0);
      check("R10", "sticky", 48'(viol_sticky_o), 48'h1f);
      check("R9", "pulse idle", 48'(viol_pulse_o), 48'h0);
      // R7 rows, R8 rejected activate kept row 7 on bank 1
      check("R7", "row b0", 48'(open_row_o[0*ROW_W +: ROW_W]), 48'd2);
      check("R8", "row b1", 48'(open_row_o[1*ROW_W +: ROW_W]), 48'd7);
      check("R7", "row b2", 48'(open_row_o[2*ROW_W +: ROW_W]), 48'd9);
      check("R7", "row b3", 48'(open_row_o[3*ROW_W +: ROW_W]), 48'd4095);

      // R11 reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      check("R11", "open after reset", 48'(bank_open_o), 48'h0);
      check("R11", "rows after reset", open_row_o, 48'h0);
      check("R11", "sticky after reset", 48'(viol_sticky_o), 48'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 and R1: same-bank spacing, one short of 8 then exactly 8
      issue(3'd1, 2'd0, 12'd11);               // t0
      issue(3'd4, 2'd0, 12'd0);                // t1
      for (int k = 0; k < 5; k++) issue(3'd0, 2'd0, 12'd0); // t2..t6
      issue(3'd1, 2'd0, 12'd12);               // t7
      check("R5", "seven cycles", 48'(viol_pulse_o), 48'b01000);
      check("R8", "closed after reject", 48'(bank_open_o), 48'h0);
      issue(3'd1, 2'd0, 12'd13);               // t8
      check("R5", "eight cycles", 48'(viol_pulse_o), 48'h0);
      check("R1", "row at limit", 48'(open_row_o[0 +: ROW_W]), 48'd13);

      // R6 and R1: cross-bank at exactly two cycles is legal
      issue(3'd0, 2'd0, 12'd0);
      issue(3'd1, 2'd3, 12'd21);
      check("R6", "two cycles", 48'(viol_pulse_o), 48'h0);
      check("R6", "open", 48'(bank_open_o), 48'b1001);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule